// File: doc/BRIEF.md
# Register Window Spill/Fill Manager

This block keeps track of the register windows of a processor whose general registers are organised as overlapping windows. It holds the current window pointer and an invalid-window mask, one bit per implemented window. It decides, for every save (call) and restore (return) the pipeline asks for, whether the step can go ahead or would run into a window that is marked invalid. A save moves the pointer down by one and a restore moves it up by one, modulo the window count.

When a step would hit an invalid window, the mode input selects the response. In the privileged (operating) mode the block raises a one-cycle overflow or underflow trap request and changes nothing. Trap dispatch belongs to other logic. In the unprivileged (user) mode the block handles the case itself. It drives a memory port through the 16 register transfers of one window, keeps the requester stalled with busy, then rotates the invalid mask by one place and completes the step. A flush request writes every live caller window out to memory, one window at a time. The register file storage and the memory addressing sit outside the block. They follow the window number and register index that the block presents on the port.

Top module: `regwin_mgr`

## Requirements
- R1: After reset the window pointer is 0, the mask is 0b00000010 (only window 1 invalid), and busy, done, both trap outputs and mem_req are 0.
- R2: A save whose window pointer minus 1 (mod N) has a clear mask bit moves the pointer to that value and pulses done in the cycle after the request, with no memory transfer.
- R3: A restore whose window pointer plus 1 (mod N) has a clear mask bit moves the pointer to that value and pulses done in the cycle after the request, with no memory transfer.
- R4: In user mode (op_mode=0), a save whose pointer minus 1 is invalid writes out window pointer minus 2. This takes 16 transfers with mem_we=1 and mem_idx counting 0 to 15, with busy high throughout. The pointer then decrements, the mask rotates right by one bit (bit i takes old bit i+1 mod N), and done pulses.
- R5: In user mode, a restore whose pointer plus 1 is invalid reads that window back. This takes 16 transfers with mem_we=0 and mem_idx counting 0 to 15. The pointer then increments, the mask rotates left by one bit (bit i takes old bit i-1 mod N), and done pulses.
- R6: In operating mode (op_mode=1), a save that would overflow pulses ovf_trap for one cycle. It leaves the pointer and the mask unchanged and starts no transfer.
- R7: In operating mode, a restore that would underflow pulses unf_trap for one cycle. It leaves the pointer and the mask unchanged and starts no transfer.
- R8: A transfer advances only in a cycle with mem_ack high. While mem_ack is low, mem_req, mem_idx and mem_win hold.
- R9: A flush writes windows pointer+1, pointer+2 and onwards (mod N), 16 transfers each. It stops before the first window whose mask bit is set, or before returning to the pointer. It then sets the mask to a single bit at pointer+1, leaves the pointer unchanged and pulses done.
- R10: When the block is idle, save beats restore and restore beats flush when requested together. Requests made while busy are ignored.
- R11: The mask is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 1 | 1 = operating mode (trap on hazard), 0 = user mode (service in place) |
| save_req | input | 1 | Request to move to the next window down |
| restore_req | input | 1 | Request to move to the next window up |
| flush_req | input | 1 | Request to write all live caller windows to memory |
| mem_ack | input | 1 | Memory accepted the current register transfer |
| busy | output | 1 | A spill, fill or flush is in progress; requester must hold |
| done | output | 1 | One-cycle pulse when a save, restore or flush completes |
| ovf_trap | output | 1 | One-cycle overflow trap request |
| unf_trap | output | 1 | One-cycle underflow trap request |
| cwp | output | $clog2(NWIN) | Current window pointer |
| wim | output | NWIN | Invalid-window mask, bit w set = window w invalid |
| mem_req | output | 1 | A register transfer is offered on the memory port |
| mem_we | output | 1 | 1 = window written to memory, 0 = window read from memory |
| mem_win | output | $clog2(NWIN) | Window being transferred |
| mem_idx | output | $clog2(REGS_PER_WIN) | Register index within the window |

## Verification
On every cycle the assertions check several rules. The two traps never coincide. A trap leaves the pointer and mask untouched. Transfers are offered only while busy and freeze without an acknowledge. The pointer moves only with done. A completed spill or fill leaves the mask rotated in the right direction, and the mask never empties. Which window gets spilled or filled, how many windows a flush walks and where it stops, how the simultaneous-request priority resolves, and the exact mask and pointer values along a long walk through all windows can only be shown by the bench's scenarios against precomputed expectations.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int REGS_PER_WIN_DEF = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2,
        ST_FLUSH = 2'd3
    } rw_state_e;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_SAVE    = 2'd1,
        OP_RESTORE = 2'd2,
        OP_FLUSH   = 2'd3
    } rw_op_e;

    typedef struct packed {
        logic save_hit;
        logic restore_hit;
    } rw_hazard_t;

    // window arithmetic modulo n, step d in [-2, +2]
    function automatic int win_step(int w, int d, int n);
        return (w + d + 2 * n) % n;
    endfunction

    // fixed priority: save, then restore, then flush
    function automatic rw_op_e pick_op(logic sv, logic rs, logic fl);
        if (sv)      return OP_SAVE;
        else if (rs) return OP_RESTORE;
        else if (fl) return OP_FLUSH;
        else         return OP_NONE;
    endfunction

endpackage

// File: rtl/regwin_hazard.sv
module regwin_hazard
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic [CW-1:0]   cwp_i,
    input  logic [NWIN-1:0] wim_i,
    output logic [CW-1:0]   cwp_m1_o,
    output logic [CW-1:0]   cwp_m2_o,
    output logic [CW-1:0]   cwp_p1_o,
    output rw_hazard_t      hz_o
);

    always_comb begin
        cwp_m1_o = CW'(win_step(int'(cwp_i), -1, NWIN));
        cwp_m2_o = CW'(win_step(int'(cwp_i), -2, NWIN));
        cwp_p1_o = CW'(win_step(int'(cwp_i),  1, NWIN));
        hz_o.save_hit    = wim_i[cwp_m1_o];
        hz_o.restore_hit = wim_i[cwp_p1_o];
    end

endmodule

// File: rtl/regwin_rotate.sv
module regwin_rotate #(
    parameter int NWIN = 8
) (
    input  logic [NWIN-1:0] wim_i,
    output logic [NWIN-1:0] rot_r_o,
    output logic [NWIN-1:0] rot_l_o
);

    for (genvar i = 0; i < NWIN; i++) begin : g_bit
        assign rot_r_o[i] = wim_i[(i + 1) % NWIN];
        assign rot_l_o[i] = wim_i[(i + NWIN - 1) % NWIN];
    end

endmodule

// File: rtl/regwin_xfer.sv
module regwin_xfer #(
    parameter int NWIN         = 8,
    parameter int REGS_PER_WIN = 16,
    localparam int CW = $clog2(NWIN),
    localparam int IW = $clog2(REGS_PER_WIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] load_win_i,
    input  logic          stop_i,
    input  logic          ack_i,
    output logic          active_o,
    output logic [CW-1:0] win_o,
    output logic [IW-1:0] idx_o,
    output logic          beat_last_o
);

    localparam logic [IW-1:0] IDX_LAST = IW'(REGS_PER_WIN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            win_o    <= '0;
            idx_o    <= '0;
        end else if (load_i) begin
            active_o <= 1'b1;
            win_o    <= load_win_i;
            idx_o    <= '0;
        end else if (stop_i) begin
            active_o <= 1'b0;
            idx_o    <= '0;
        end else if (active_o && ack_i) begin
            idx_o <= idx_o + 1'b1;
        end
    end

    assign beat_last_o = active_o && ack_i && (idx_o == IDX_LAST);

endmodule

// File: rtl/regwin_mgr.sv
module regwin_mgr
    import regwin_pkg::*;
#(
    parameter int NWIN         = 8,
    parameter int REGS_PER_WIN = REGS_PER_WIN_DEF,
    localparam int CW = $clog2(NWIN),
    localparam int IW = $clog2(REGS_PER_WIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_mode,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            flush_req,
    input  logic            mem_ack,
    output logic            busy,
    output logic            done,
    output logic            ovf_trap,
    output logic            unf_trap,
    output logic [CW-1:0]   cwp,
    output logic [NWIN-1:0] wim,
    output logic            mem_req,
    output logic            mem_we,
    output logic [CW-1:0]   mem_win,
    output logic [IW-1:0]   mem_idx
);

    localparam logic [NWIN-1:0] WIM_RST = NWIN'(2);

    rw_state_e       state;
    rw_op_e          op;
    rw_hazard_t      hz;
    logic [CW-1:0]   cwp_m1, cwp_m2, cwp_p1;
    logic [NWIN-1:0] wim_rr, wim_rl, wim_single;
    logic            xfer_load, xfer_stop, beat_last;
    logic [CW-1:0]   xfer_win, flush_next;
    logic            flush_end;

    regwin_hazard #(.NWIN(NWIN)) u_hazard (
        .cwp_i    (cwp),
        .wim_i    (wim),
        .cwp_m1_o (cwp_m1),
        .cwp_m2_o (cwp_m2),
        .cwp_p1_o (cwp_p1),
        .hz_o     (hz)
    );

    regwin_rotate #(.NWIN(NWIN)) u_rotate (
        .wim_i   (wim),
        .rot_r_o (wim_rr),
        .rot_l_o (wim_rl)
    );

    regwin_xfer #(.NWIN(NWIN), .REGS_PER_WIN(REGS_PER_WIN)) u_xfer (
        .clk         (clk),
        .rst         (rst),
        .load_i      (xfer_load),
        .load_win_i  (xfer_win),
        .stop_i      (xfer_stop),
        .ack_i       (mem_ack),
        .active_o    (mem_req),
        .win_o       (mem_win),
        .idx_o       (mem_idx),
        .beat_last_o (beat_last)
    );

    assign op         = pick_op(save_req, restore_req, flush_req);
    assign wim_single = NWIN'(1) << cwp_p1;
    assign flush_next = CW'(win_step(int'(mem_win), 1, NWIN));
    assign flush_end  = (flush_next == cwp) || wim[flush_next];
    assign busy       = (state != ST_IDLE);
    assign mem_we     = (state == ST_SPILL) || (state == ST_FLUSH);

    // transfer sequencer control
    always_comb begin
        xfer_load = 1'b0;
        xfer_stop = 1'b0;
        xfer_win  = '0;
        unique case (state)
            ST_IDLE: begin
                unique case (op)
                    OP_SAVE: if (hz.save_hit && !op_mode) begin
                        xfer_load = 1'b1;
                        xfer_win  = cwp_m2;
                    end
                    OP_RESTORE: if (hz.restore_hit && !op_mode) begin
                        xfer_load = 1'b1;
                        xfer_win  = cwp_p1;
                    end
                    OP_FLUSH: if (!hz.restore_hit) begin
                        xfer_load = 1'b1;
                        xfer_win  = cwp_p1;
                    end
                    default: ;
                endcase
            end
            ST_SPILL, ST_FILL: xfer_stop = beat_last;
            ST_FLUSH: begin
                if (beat_last) begin
                    if (flush_end) begin
                        xfer_stop = 1'b1;
                    end else begin
                        xfer_load = 1'b1;
                        xfer_win  = flush_next;
                    end
                end
            end
            default: ;
        endcase
    end

    // window state and completion
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cwp      <= '0;
            wim      <= WIM_RST;
            done     <= 1'b0;
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
        end else begin
            done     <= 1'b0;
            ovf_trap <= 1'b0;
            unf_trap <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    unique case (op)
                        OP_SAVE: begin
                            if (!hz.save_hit) begin
                                cwp  <= cwp_m1;
                                done <= 1'b1;
                            end else if (op_mode) begin
                                ovf_trap <= 1'b1;
                            end else begin
                                state <= ST_SPILL;
                            end
                        end
                        OP_RESTORE: begin
                            if (!hz.restore_hit) begin
                                cwp  <= cwp_p1;
                                done <= 1'b1;
                            end else if (op_mode) begin
                                unf_trap <= 1'b1;
                            end else begin
                                state <= ST_FILL;
                            end
                        end
                        OP_FLUSH: begin
                            if (hz.restore_hit) begin
                                wim  <= wim_single;
                                done <= 1'b1;
                            end else begin
                                state <= ST_FLUSH;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_SPILL: begin
                    if (beat_last) begin
                        state <= ST_IDLE;
                        cwp   <= cwp_m1;
                        wim   <= wim_rr;
                        done  <= 1'b1;
                    end
                end
                ST_FILL: begin
                    if (beat_last) begin
                        state <= ST_IDLE;
                        cwp   <= cwp_p1;
                        wim   <= wim_rl;
                        done  <= 1'b1;
                    end
                end
                ST_FLUSH: begin
                    if (beat_last && flush_end) begin
                        state <= ST_IDLE;
                        wim   <= wim_single;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/regwin_mgr_sva.sv
module regwin_mgr_sva #(
    parameter int NWIN         = 8,
    parameter int REGS_PER_WIN = 16,
    localparam int CW = $clog2(NWIN),
    localparam int IW = $clog2(REGS_PER_WIN)
) (
    input logic            clk,
    input logic            rst,
    input logic            op_mode,
    input logic            mem_ack,
    input logic            busy,
    input logic            done,
    input logic            ovf_trap,
    input logic            unf_trap,
    input logic [CW-1:0]   cwp,
    input logic [NWIN-1:0] wim,
    input logic            mem_req,
    input logic            mem_we,
    input logic [CW-1:0]   mem_win,
    input logic [IW-1:0]   mem_idx
);

    logic [NWIN-1:0] prev_wim;
    logic [NWIN-1:0] exp_rr, exp_rl;

    always_ff @(posedge clk) prev_wim <= wim;

    assign exp_rr = (prev_wim >> 1) | (prev_wim << (NWIN - 1));
    assign exp_rl = (prev_wim << 1) | (prev_wim >> (NWIN - 1));

    AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ovf_trap && unf_trap)); // R6

    AST_TRAP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ovf_trap || unf_trap) |-> ($stable(cwp) && $stable(wim))); // R7

    AST_MEM_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R4

    AST_HOLD_NOACK: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_idx) && $stable(mem_win))); // R8

    AST_CWP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (cwp != $past(cwp)) |-> done); // R2

    AST_SPILL_ROT: assert property (@(posedge clk) disable iff (rst)
        (done && $past(mem_req && mem_we) && (cwp != $past(cwp))) |-> (wim == exp_rr)); // R4

    AST_FILL_ROT: assert property (@(posedge clk) disable iff (rst)
        (done && $past(mem_req && !mem_we) && (cwp != $past(cwp))) |-> (wim == exp_rl)); // R5

    AST_WIM_LIVE: assert property (@(posedge clk) disable iff (rst)
        wim != '0); // R11

endmodule

bind regwin_mgr regwin_mgr_sva #(.NWIN(NWIN), .REGS_PER_WIN(REGS_PER_WIN)) u_sva (.*);

// File: tb/tb_regwin_mgr.sv
module tb_regwin_mgr;

    localparam int NWIN = 8;
    localparam int CW   = 3;
    localparam int IW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_mode = 1'b0;
    logic save_req = 1'b0, restore_req = 1'b0, flush_req = 1'b0;
    logic mem_ack = 1'b1;
    logic busy, done, ovf_trap, unf_trap, mem_req, mem_we;
    logic [CW-1:0] cwp, mem_win;
    logic [NWIN-1:0] wim;
    logic [IW-1:0] mem_idx;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk; // 125 MHz

    regwin_mgr #(.NWIN(NWIN), .REGS_PER_WIN(16)) dut (.*);

    // op codes of the table: 1 save, 2 restore, 3 flush
    // kind: 0 done, 1 overflow trap, 2 underflow trap
    typedef struct packed {
        logic [3:0] req;
        logic [1:0] op;
        logic       opm;
        logic [1:0] kind;
        logic [7:0] beats;
        logic [2:0] first_win;
        logic [2:0] last_win;
        logic       we;
        logic [2:0] cwp;
        logic [7:0] wim;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd5,  2'd2, 1'b0, 2'd0, 8'd16, 3'd1, 3'd1, 1'b0, 3'd1, 8'h04}, // R5 fill window 1
        '{4'd7,  2'd2, 1'b1, 2'd2, 8'd0,  3'd0, 3'd0, 1'b0, 3'd1, 8'h04}, // R7
        '{4'd2,  2'd1, 1'b0, 2'd0, 8'd0,  3'd0, 3'd0, 1'b0, 3'd0, 8'h04}, // R2
        '{4'd2,  2'd1, 1'b0, 2'd0, 8'd0,  3'd0, 3'd0, 1'b0, 3'd7, 8'h04}, // R2 wrap
        '{4'd2,  2'd1, 1'b0, 2'd0, 8'd0,  3'd0, 3'd0, 1'b0, 3'd6, 8'h04},
        '{4'd2,  2'd1, 1'b0, 2'd0, 8'd0,  3'd0, 3'd0, 1'b0, 3'd5, 8'h04},
        '{4'd2,  2'd1, 1'b0, 2'd0, 8'd0,  3'd0, 3'd0, 1'b0, 3'd4, 8'h04},
        '{4'd2,  2'd1, 1'b0, 2'd0, 8'd0,  3'd0, 3'd0, 1'b0, 3'd3, 8'h04},
        '{4'd6,  2'd1, 1'b1, 2'd1, 8'd0,  3'd0, 3'd0, 1'b0, 3'd3, 8'h04}, // R6
        '{4'd4,  2'd1, 1'b0, 2'd0, 8'd16, 3'd1, 3'd1, 1'b1, 3'd2, 8'h02}, // R4 spill window 1
        '{4'd9,  2'd3, 1'b0, 2'd0, 8'd96, 3'd3, 3'd0, 1'b1, 3'd2, 8'h08}, // R9 windows 3..0
        '{4'd5,  2'd2, 1'b0, 2'd0, 8'd16, 3'd3, 3'd3, 1'b0, 3'd3, 8'h10}, // R5 fill window 3
        '{4'd7,  2'd2, 1'b1, 2'd2, 8'd0,  3'd0, 3'd0, 1'b0, 3'd3, 8'h10}, // R7
        '{4'd2,  2'd1, 1'b0, 2'd0, 8'd0,  3'd0, 3'd0, 1'b0, 3'd2, 8'h10}, // R2
        '{4'd3,  2'd2, 1'b0, 2'd0, 8'd0,  3'd0, 3'd0, 1'b0, 3'd3, 8'h10}  // R3
    };

    logic [1:0] res_kind;
    int         res_beats;
    logic [2:0] res_first, res_last;
    logic       res_we;
    int         res_idx_bad;
    logic       hung = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic wait_end();
        int guard = 0;
        res_beats = 0; res_first = '0; res_last = '0; res_we = 1'b0; res_idx_bad = 0;
        while (!(done || ovf_trap || unf_trap) && guard < 4000) begin
            if (mem_req && mem_ack) begin
                if (res_beats == 0) res_first = mem_win;
                res_last = mem_win;
                res_we   = mem_we;
                if (int'(mem_idx) != (res_beats % 16)) res_idx_bad++;
                res_beats++;
            end
            @(negedge clk);
            guard++;
        end
        if (guard >= 4000) hung = 1'b1;
        res_kind = done ? 2'd0 : (ovf_trap ? 2'd1 : 2'd2);
    endtask

    task automatic issue(input logic [1:0] op, input logic opm);
        @(negedge clk);
        op_mode     = opm;
        save_req    = (op == 2'd1);
        restore_req = (op == 2'd2);
        flush_req   = (op == 2'd3);
        @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0; flush_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cwp", 32'(cwp), 32'd0);
        check("R1 wim", 32'(wim), 32'h02);
        check("R1 outputs", {28'd0, busy, done, ovf_trap | unf_trap, mem_req}, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
            issue(VECS[i].op, VECS[i].opm);
            wait_end();
            check({tg, " hang"}, 32'(hung), 32'd0);
            check({tg, " kind"}, 32'(res_kind), 32'(VECS[i].kind));
            check({tg, " beats"}, 32'(res_beats), 32'(VECS[i].beats));
            if (VECS[i].beats != 0) begin
                check({tg, " first win"}, 32'(res_first), 32'(VECS[i].first_win));
                check({tg, " last win"}, 32'(res_last), 32'(VECS[i].last_win));
                check({tg, " we"}, 32'(res_we), 32'(VECS[i].we));
                check({tg, " idx order"}, 32'(res_idx_bad), 32'd0);
            end
            check({tg, " cwp"}, 32'(cwp), 32'(VECS[i].cwp));
            check({tg, " wim"}, 32'(wim), 32'(VECS[i].wim));
            @(negedge clk);
            check({tg, " pulse ends"}, {29'd0, done, ovf_trap, unf_trap}, 32'd0);
        end

        // move to cwp 5 with wim 0x10
        for (int k = 0; k < 6; k++) begin
            issue(2'd1, 1'b0);
            wait_end();
        end
        check("R2 walk cwp", 32'(cwp), 32'd5);

        // R8 stall and R10 ignore-while-busy during spill of window 3
        issue(2'd1, 1'b0);
        check("R4 busy", 32'(busy), 32'd1);
        repeat (3) @(negedge clk);
        mem_ack = 1'b0;
        begin
            logic [3:0] held_idx;
            logic [2:0] held_win;
            held_idx = mem_idx;
            held_win = mem_win;
            restore_req = 1'b1;
            @(negedge clk);
            restore_req = 1'b0;
            repeat (2) @(negedge clk);
            check("R8 idx hold", 32'(mem_idx), 32'(held_idx));
            check("R8 win hold", 32'(mem_win), 32'(held_win));
            check("R8 req hold", 32'(mem_req), 32'd1);
            check("R8 idx value", 32'(held_idx), 32'd3);
        end
        mem_ack = 1'b1;
        wait_end();
        check("R4 stalled spill cwp", 32'(cwp), 32'd4);
        check("R4 stalled spill wim", 32'(wim), 32'h08);
        @(negedge clk);
        check("R10 restore while busy ignored busy", 32'(busy), 32'd0);
        check("R10 restore while busy ignored cwp", 32'(cwp), 32'd4);

        // R10 save wins over restore: operating mode, save hazard at cwp 4
        @(negedge clk);
        op_mode = 1'b1; save_req = 1'b1; restore_req = 1'b1;
        @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0;
        check("R10 save over restore trap", {30'd0, ovf_trap, unf_trap}, 32'h2);
        check("R10 save over restore cwp", 32'(cwp), 32'd4);

        // R10 restore wins over flush
        @(negedge clk);
        op_mode = 1'b0; restore_req = 1'b1; flush_req = 1'b1;
        @(negedge clk);
        restore_req = 1'b0; flush_req = 1'b0;
        check("R10 restore over flush done", 32'(done), 32'd1);
        check("R10 restore over flush cwp", 32'(cwp), 32'd5);
        check("R10 restore over flush busy", 32'(busy), 32'd0);
        check("R11 wim nonzero", 32'(wim != 0), 32'd1);

        finish_run();
    end

endmodule